// File: doc/BRIEF.md
# 3x3 Gaussian Smoothing Stream Filter

This block smooths an 8-bit single-channel video stream with a 3x3 Gaussian kernel, as a noise-reduction stage ahead of gradient or edge detection. Pixels enter one per beat on a valid/ready stream that carries a start-of-frame flag (user) and an end-of-line flag (last). Pixels leave on a stream of the same form. Every input frame gives an output frame of the same size.

Frame width and height are fixed by parameters; the defaults are 1280 by 720. Two line stores keep the two rows before the current one, and a three-column window register feeds the kernel. Each output pixel is centred one row and one column behind the input scan. The final column of each line and the final row of each frame are produced by internal bubble steps that take no input. Edge pixels take the value of the nearest real row or column, so no pixel outside the frame is ever invented.

Top module: `gauss3_stream`

## Requirements
- R1: An interior output pixel at (row r, column c) equals (S + 8) >> 4, where S is the weighted sum of the 3x3 input neighbourhood centred on (r, c). The weights are 1 2 1 / 2 4 2 / 1 2 1, so they total 16.
- R2: At frame edges, a neighbour row or column outside the frame is replaced by the nearest row or column inside it, so the output frame has WIDTH x HEIGHT pixels, the same as the input.
- R3: After the last input pixel of a frame, the block emits all remaining output pixels of that frame without further input, and keeps s_ready_o low during those bubble steps.
- R4: m_user_o is 1 on the first output pixel of each frame (row 0, column 0) and 0 on every other output pixel.
- R5: m_last_o is 1 on every output pixel in column WIDTH-1 and 0 on every other output pixel.
- R6: While m_valid_o is 1 and m_ready_i is 0, m_data_o, m_user_o and m_last_o hold steady. No output pixel is lost or repeated under any pattern of backpressure.
- R7: An input pixel is taken only on a cycle where s_valid_i and s_ready_o are both 1. Input gaps do not disturb the result. The frame position comes from internal counters: s_user_i must be 1 exactly on the first pixel of a frame, and s_last_i exactly on column WIDTH-1.
- R8: While rst_ni is low and directly after reset, m_valid_o is 0 and s_ready_o is 1.
- R9: Frames may follow one another with no gap. The first pixel of the next frame is accepted straight after the previous frame's flush, and line-store contents from the previous frame have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_valid_i | input | 1 | Input pixel valid |
| s_ready_o | output | 1 | Block can take an input pixel |
| s_data_i | input | PIX_W | Input pixel value |
| s_user_i | input | 1 | Input start-of-frame flag |
| s_last_i | input | 1 | Input end-of-line flag |
| m_valid_o | output | 1 | Output pixel valid |
| m_ready_i | input | 1 | Downstream can take an output pixel |
| m_data_o | output | PIX_W | Smoothed pixel value |
| m_user_o | output | 1 | Output start-of-frame flag |
| m_last_o | output | 1 | Output end-of-line flag |

## Verification
The bench compares every pixel of small 16x8 frames with a reference model. The test frames are ramps, irregular patterns, a saturated frame and a checkerboard. An error in rounding, in the weights or in edge replication shows up as wrong values in the corner rows and columns or in the checkerboard cells. Irregular input gaps and output stalls are applied together, and frames are sent back to back. A design that drops or repeats pixels under stall, changes its output while it is stalled, or lets stale line-store data reach the first rows of a new frame would shift the whole comparison or change the top-row values. The final row of each frame must arrive with no input after the frame, which exposes a design that waits for the next frame before it flushes.

// File: rtl/gauss3_pkg.sv
package gauss3_pkg;
  typedef enum logic [1:0] {
    ROW_FIRST,
    ROW_SECOND,
    ROW_BODY,
    ROW_FLUSH
  } row_kind_e;
endpackage

// File: rtl/gauss3_line_store.sv
module gauss3_line_store #(
  parameter int WIDTH  = 1280,
  parameter int PIX_W  = 8,
  parameter int NROWS  = 2,
  localparam int AW    = $clog2(WIDTH)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [AW-1:0]                addr_i,
  input  logic [PIX_W-1:0]             wr_pix_i,
  // rd_o[NROWS-1] is the newest stored row
  output logic [NROWS-1:0][PIX_W-1:0]  rd_o
);
  for (genvar k = 0; k < NROWS; k++) begin : g_row
    logic [PIX_W-1:0] row_mem [WIDTH];
    logic [PIX_W-1:0] src;
    if (k == NROWS - 1) begin : g_head
      assign src = wr_pix_i;
    end else begin : g_chain
      assign src = rd_o[k+1];
    end
    assign rd_o[k] = row_mem[addr_i];
    always_ff @(posedge clk_i) begin
      if (wr_en_i) row_mem[addr_i] <= src;
    end
  end

  AST_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (32'(addr_i) < WIDTH)) else $error("line store address out of range"); // R2
endmodule

// File: rtl/gauss3_window.sv
module gauss3_window #(
  parameter int PIX_W = 8,
  localparam int SHIFT = 4,
  localparam int SW    = PIX_W + SHIFT,
  localparam int RND   = 1 << (SHIFT - 1)
) (
  input  logic                    clk_i,
  input  logic                    step_i,
  input  logic                    load_all_i,  // first column of a line
  input  logic                    edge_i,      // trailing bubble column
  input  logic [2:0][PIX_W-1:0]   col_i,       // [0]=top [1]=mid [2]=bot
  output logic [PIX_W-1:0]        pix_o        // kernel on the next window
);
  logic [PIX_W-1:0] win_q [3][3];  // [column][row], column 0 = left
  logic [PIX_W-1:0] nxt   [3][3];
  logic [SW-1:0]    hs    [3];
  logic [SW-1:0]    total;

  always_comb begin
    for (int r = 0; r < 3; r++) begin
      if (load_all_i) begin
        nxt[0][r] = col_i[r];
        nxt[1][r] = col_i[r];
        nxt[2][r] = col_i[r];
      end else begin
        nxt[0][r] = win_q[1][r];
        nxt[1][r] = win_q[2][r];
        nxt[2][r] = edge_i ? win_q[2][r] : col_i[r];
      end
    end
  end

  always_comb begin
    for (int r = 0; r < 3; r++) begin
      hs[r] = SW'(nxt[0][r]) + (SW'(nxt[1][r]) << 1) + SW'(nxt[2][r]);
    end
    total = hs[0] + (hs[1] << 1) + hs[2] + SW'(RND);
    pix_o = total[SW-1:SHIFT];
  end

  always_ff @(posedge clk_i) begin
    if (step_i) begin
      for (int c = 0; c < 3; c++) begin
        for (int r = 0; r < 3; r++) win_q[c][r] <= nxt[c][r];
      end
    end
  end
endmodule

// File: rtl/gauss3_stream.sv
module gauss3_stream
  import gauss3_pkg::*;
#(
  parameter int WIDTH  = 1280,
  parameter int HEIGHT = 720,
  parameter int PIX_W  = 8,
  localparam int XW    = $clog2(WIDTH + 1),
  localparam int YW    = $clog2(HEIGHT + 1),
  localparam int AW    = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             s_valid_i,
  output logic             s_ready_o,
  input  logic [PIX_W-1:0] s_data_i,
  input  logic             s_user_i,
  input  logic             s_last_i,
  output logic             m_valid_o,
  input  logic             m_ready_i,
  output logic [PIX_W-1:0] m_data_o,
  output logic             m_user_o,
  output logic             m_last_o
);
  localparam logic [XW-1:0] X_END  = XW'(WIDTH);
  localparam logic [XW-1:0] X_LAST = XW'(WIDTH - 1);
  localparam logic [YW-1:0] Y_END  = YW'(HEIGHT);
  localparam logic [YW-1:0] Y_LAST = YW'(HEIGHT - 1);

  // scan position over a (HEIGHT+1) x (WIDTH+1) grid; extra row/column are bubbles
  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  row_kind_e     kind;
  logic          col_edge, need_in, need_out, out_free, step;

  always_comb begin
    if (y_q == Y_END)     kind = ROW_FLUSH;
    else if (y_q == '0)   kind = ROW_FIRST;
    else if (y_q == YW'(1)) kind = ROW_SECOND;
    else                  kind = ROW_BODY;
  end

  assign col_edge  = (x_q == X_END);
  assign need_in   = (kind != ROW_FLUSH) && !col_edge;
  assign need_out  = (y_q != '0) && (x_q != '0);
  assign out_free  = !m_valid_o || m_ready_i;
  assign step      = (!need_in || s_valid_i) && (!need_out || out_free);
  assign s_ready_o = need_in && (!need_out || out_free);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
    end else if (step) begin
      if (col_edge) begin
        x_q <= '0;
        y_q <= (y_q == Y_END) ? '0 : y_q + YW'(1);
      end else begin
        x_q <= x_q + XW'(1);
      end
    end
  end

  // column taps: rows y-2, y-1, y clamped into the frame
  logic [AW-1:0]          addr;
  logic [1:0][PIX_W-1:0]  prev;  // [1] = row y-1, [0] = row y-2
  logic [2:0][PIX_W-1:0]  col;

  assign addr = col_edge ? AW'(WIDTH - 1) : x_q[AW-1:0];

  always_comb begin
    unique case (kind)
      ROW_FIRST:  col = {s_data_i, s_data_i, s_data_i};
      ROW_SECOND: col = {s_data_i, prev[1], prev[1]};
      ROW_BODY:   col = {s_data_i, prev[1], prev[0]};
      default:    col = {prev[1], prev[1], prev[0]};
    endcase
  end

  gauss3_line_store #(.WIDTH(WIDTH), .PIX_W(PIX_W), .NROWS(2)) u_lines (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (step && !col_edge),
    .addr_i   (addr),
    .wr_pix_i (col[2]),
    .rd_o     (prev)
  );

  logic [PIX_W-1:0] smooth;

  gauss3_window #(.PIX_W(PIX_W)) u_win (
    .clk_i      (clk_i),
    .step_i     (step),
    .load_all_i (x_q == '0),
    .edge_i     (col_edge),
    .col_i      (col),
    .pix_o      (smooth)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_valid_o <= 1'b0;
      m_data_o  <= '0;
      m_user_o  <= 1'b0;
      m_last_o  <= 1'b0;
    end else if (step && need_out) begin
      m_valid_o <= 1'b1;
      m_data_o  <= smooth;
      m_user_o  <= (y_q == YW'(1)) && (x_q == XW'(1));
      m_last_o  <= col_edge;
    end else if (m_ready_i) begin
      m_valid_o <= 1'b0;
    end
  end

  // output-side position, kept only for the checks below
  logic [XW-1:0] chk_col_q;
  logic [YW-1:0] chk_row_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_col_q <= '0;
      chk_row_q <= '0;
    end else if (m_valid_o && m_ready_i) begin
      if (chk_col_q == X_LAST) begin
        chk_col_q <= '0;
        chk_row_q <= (chk_row_q == Y_LAST) ? '0 : chk_row_q + YW'(1);
      end else begin
        chk_col_q <= chk_col_q + XW'(1);
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_data_o) && $stable(m_user_o)
      && $stable(m_last_o)) else $error("output changed under stall"); // R6
  AST_LAST_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o |-> (m_last_o == (chk_col_q == X_LAST))) else $error("last misplaced"); // R5
  AST_USER_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o |-> (m_user_o == ((chk_col_q == '0) && (chk_row_q == '0))))
    else $error("user misplaced"); // R4
  AST_FLUSH_NO_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((y_q == Y_END) || col_edge) |-> !s_ready_o) else $error("input taken in bubble"); // R3
  AST_IN_MARKERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_valid_i && s_ready_o |-> (s_user_i == ((x_q == '0) && (y_q == '0)))
      && (s_last_i == (x_q == X_LAST))) else $error("input markers off position"); // R7
endmodule

// File: tb/gauss3_stream_tb_top.sv
module gauss3_stream_tb_top;
  localparam int W  = 16;
  localparam int H  = 8;
  localparam int NP = W * H;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0, s_ready, s_user = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = '0;
  logic       m_valid, m_ready = 1'b0, m_user, m_last;
  logic [7:0] m_data;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gauss3_stream #(.WIDTH(W), .HEIGHT(H), .PIX_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .s_valid_i(s_valid), .s_ready_o(s_ready), .s_data_i(s_data),
    .s_user_i(s_user), .s_last_i(s_last),
    .m_valid_o(m_valid), .m_ready_i(m_ready), .m_data_o(m_data),
    .m_user_o(m_user), .m_last_o(m_last)
  );

  function automatic int img(int f, int y, int x);
    case (f % 4)
      0: return (x * 13 + y * 29) & 255;
      1: return (x * x * 7 + y * 53 + x * y * 11 + 91) & 255;
      2: return 255;
      default: return ((x + y) % 2 == 0) ? 255 : 0;
    endcase
  endfunction

  function automatic int clampi(int v, int hi);
    return (v < 0) ? 0 : (v > hi) ? hi : v;
  endfunction

  function automatic int ref_pix(int f, int y, int x);
    int s = 0;
    for (int dy = -1; dy <= 1; dy++)
      for (int dx = -1; dx <= 1; dx++)
        s += ((dy == 0) ? 2 : 1) * ((dx == 0) ? 2 : 1)
             * img(f, clampi(y + dy, H - 1), clampi(x + dx, W - 1));
    return (s + 8) >> 4;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_stream(int first_f, int nframes, int in_mode, int out_mode);
    int total = nframes * NP;
    int got = 0;
    fork
      begin : drive
        for (int k = 0; k < total; ) begin
          int f = first_f + k / NP;
          int y = (k % NP) / W;
          int x = k % W;
          @(negedge clk);
          if (in_mode != 0 && (cyc % 5 == 1 || cyc % 7 == 3)) begin
            s_valid = 1'b0;
          end else begin
            s_valid = 1'b1;
            s_data  = 8'(img(f, y, x));
            s_user  = (x == 0 && y == 0);
            s_last  = (x == W - 1);
          end
          #1;
          if (s_valid && s_ready) k++;
        end
        @(negedge clk);
        s_valid = 1'b0;
      end
      begin : monitor
        bit         was_stall = 0;
        logic [7:0] hd = '0;
        logic       hu = 0, hl = 0;
        int         idle = 0;
        while (got < total && idle < 4 * NP) begin
          @(negedge clk);
          m_ready = (out_mode == 0) ? 1'b1 : ((cyc % 3 == 0) || (cyc % 11 == 4)) ? 1'b0 : 1'b1;
          #1;
          if (was_stall)
            chk(m_valid && m_data == hd && m_user == hu && m_last == hl,
                "R6 stall hold", int'(m_data), int'(hd));
          if (m_valid && m_ready) begin
            int f = first_f + got / NP;
            int y = (got % NP) / W;
            int x = got % W;
            int e = ref_pix(f, y, x);
            bit brd = (x == 0 || y == 0 || x == W - 1 || y == H - 1);
            chk(int'(m_data) == e, brd ? "R2 border pixel" : "R1 interior pixel",
                int'(m_data), e);
            chk(m_user == (x == 0 && y == 0), "R4 user flag", int'(m_user),
                int'(x == 0 && y == 0));
            chk(m_last == (x == W - 1), "R5 last flag", int'(m_last), int'(x == W - 1));
            got++;
            idle = 0;
          end else begin
            idle++;
          end
          was_stall = m_valid && !m_ready;
          hd = m_data; hu = m_user; hl = m_last;
        end
      end
    join
    chk(got == total, "R3 flush count", got, total);
    // nothing extra appears after the frame
    repeat (3) begin
      @(negedge clk);
      m_ready = 1'b1;
      #1;
      chk(!m_valid, "R6 no duplicate", int'(m_valid), 0);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!m_valid, "R8 valid in reset", int'(m_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!m_valid, "R8 valid after reset", int'(m_valid), 0);
    chk(s_ready, "R8 ready after reset", int'(s_ready), 1);
  endtask

  task automatic t_plain;       run_stream(0, 1, 0, 0); endtask // R1 R2 R4 R5
  task automatic t_input_gaps;  run_stream(1, 1, 1, 0); endtask // R7
  task automatic t_backpressure; run_stream(3, 1, 0, 1); endtask // R6
  task automatic t_back_to_back; run_stream(2, 3, 1, 1); endtask // R9 R3

  initial begin
    t_reset();
    t_plain();
    t_input_gaps();
    t_backpressure();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule